// File: doc/BRIEF.md
# Control-Transfer Next-PC Unit

This block is the combinational decision point for control flow in a scalar integer core. Each cycle the decode stage gives it the current program counter, the major opcode, the 3-bit condition field, the destination register index, both source register values and three offsets that the immediate decoder has already extracted: a 13-bit conditional-branch offset, a 21-bit PC-relative jump offset and a 12-bit register-jump offset. From these it produces the address of the next instruction, a flag saying that control left the sequential path, the return address with its register-file write enable, and a flag for a target that is not 4-byte aligned.

Inside, a control module decodes the opcode and condition field. It receives three comparison flags from a datapath module and sends that module a small strobe bundle: which target to select and whether to write the link. The datapath holds the comparator, the three target adders and the final multiplexer. Arithmetic wraps modulo 2^XLEN. Flushing, prediction and trap handling are done by the surrounding pipeline from the outputs.

Top module: `nextpc_unit`

## Requirements
- R1: Opcode 0x63 is a conditional branch, 0x6F a PC-relative jump and 0x67 with condition field 0 a register jump. Any other combination, including 0x67 with a nonzero condition field, gives nextPc = pcCur + 4, taken = 0 and linkWe = 0.
- R2: A conditional branch with condition field 0 is taken when the two register values are equal. With field 1 it is taken when they differ.
- R3: A conditional branch with field 4 is taken when rs1 < rs2 as signed two's-complement values. With field 5 it is taken when rs1 >= rs2, signed.
- R4: A conditional branch with field 6 is taken when rs1 < rs2 as unsigned values. With field 7 it is taken when rs1 >= rs2, unsigned.
- R5: A conditional branch with field 2 or 3 is never taken: nextPc = pcCur + 4 and taken = 0, whatever the operands are.
- R6: A taken conditional branch gives nextPc = pcCur + sign-extended branch offset, with bit 0 of the offset treated as zero. An untaken one gives pcCur + 4 with taken = 0.
- R7: A PC-relative jump is always taken, with nextPc = pcCur + sign-extended 21-bit offset and bit 0 of the offset treated as zero.
- R8: A register jump is always taken, with nextPc = (rs1 + sign-extended 12-bit offset) and bit 0 cleared.
- R9: linkVal always equals pcCur + 4. linkWe is 1 only for the two jump forms and only when rdIdx is nonzero. Conditional branches never assert it.
- R10: misaligned is 1 exactly when taken is 1 and bit 1 of nextPc is 1.
- R11: All address sums wrap modulo 2^XLEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pcCur | input | XLEN | Address of the current instruction |
| opcode | input | 7 | Major opcode field |
| funct3 | input | 3 | Condition / sub-operation field |
| rdIdx | input | 5 | Destination register index |
| rs1Val | input | XLEN | First source register value |
| rs2Val | input | XLEN | Second source register value |
| offB | input | 13 | Conditional branch offset, bit 0 ignored |
| offJ | input | 21 | PC-relative jump offset, bit 0 ignored |
| offI | input | 12 | Register jump offset |
| nextPc | output | XLEN | Address of the next instruction |
| taken | output | 1 | Control left the sequential path |
| linkVal | output | XLEN | Return address for the destination register |
| linkWe | output | 1 | Write enable for the return address |
| misaligned | output | 1 | Taken target is not 4-byte aligned |

## Verification
The embedded checks assume that the inputs have settled to known values when they are evaluated. They also assume XLEN is wider than the 21-bit jump offset, so sign extension is well defined. The stimulus changes all inputs together, one vector per cycle, just after the rising edge, and compares the outputs at the falling edge. It covers every condition code, including the two reserved ones. Operands are chosen to sit on the sign boundary, where signed and unsigned order disagree, and some offsets have bit 0 or bit 1 set so that the alignment paths are exercised.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;
  localparam int OPC_W   = 7;
  localparam int F3_W    = 3;
  localparam int RIDX_W  = 5;
  localparam int OFFB_W  = 13;
  localparam int OFFJ_W  = 21;
  localparam int OFFI_W  = 12;

  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'h63;
  localparam logic [OPC_W-1:0] OPC_JUMP   = 7'h6F;
  localparam logic [OPC_W-1:0] OPC_REGJMP = 7'h67;

  typedef enum logic [1:0] {
    TGT_SEQ = 2'd0,
    TGT_BR  = 2'd1,
    TGT_JMP = 2'd2,
    TGT_REG = 2'd3
  } tgtSel_e;

  typedef struct packed {
    tgtSel_e tgtSel;
    logic    linkWr;
  } ctrlStrobe_t;

  typedef struct packed {
    logic eq;
    logic ltS;
    logic ltU;
  } cmpFlags_t;
endpackage

// File: rtl/nextpc_ctrl.sv
module nextpc_ctrl
  import nextpc_pkg::*;
(
  input  logic [OPC_W-1:0]  opcode,
  input  logic [F3_W-1:0]   funct3,
  input  logic [RIDX_W-1:0] rdIdx,
  input  cmpFlags_t         cmpFlags,
  output ctrlStrobe_t       strobe
);
  logic isBranch;
  logic isJump;
  logic isRegJmp;
  logic condTrue;

  always_comb begin
    isBranch = (opcode == OPC_BRANCH);
    isJump   = (opcode == OPC_JUMP);
    isRegJmp = (opcode == OPC_REGJMP) && (funct3 == 3'd0);
  end

  always_comb begin
    unique case (funct3)
      3'd0:    condTrue = cmpFlags.eq;
      3'd1:    condTrue = !cmpFlags.eq;
      3'd4:    condTrue = cmpFlags.ltS;
      3'd5:    condTrue = !cmpFlags.ltS;
      3'd6:    condTrue = cmpFlags.ltU;
      3'd7:    condTrue = !cmpFlags.ltU;
      default: condTrue = 1'b0;
    endcase
  end

  always_comb begin
    strobe.tgtSel = TGT_SEQ;
    strobe.linkWr = 1'b0;
    if (isJump) begin
      strobe.tgtSel = TGT_JMP;
      strobe.linkWr = (rdIdx != '0);
    end else if (isRegJmp) begin
      strobe.tgtSel = TGT_REG;
      strobe.linkWr = (rdIdx != '0);
    end else if (isBranch && condTrue) begin
      strobe.tgtSel = TGT_BR;
    end
  end

  always_comb begin
    if (strobe.linkWr) begin
      AST_LINK_RD_NONZERO: assert (rdIdx != '0); // R9
      AST_LINK_ONLY_JUMPS: assert (opcode != OPC_BRANCH); // R9
    end
    if (opcode == OPC_BRANCH && (funct3 == 3'd2 || funct3 == 3'd3)) begin
      AST_RESERVED_COND: assert (strobe.tgtSel == TGT_SEQ); // R5
    end
  end
endmodule

// File: rtl/nextpc_dp.sv
module nextpc_dp
  import nextpc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]   pcCur,
  input  logic [XLEN-1:0]   rs1Val,
  input  logic [XLEN-1:0]   rs2Val,
  input  logic [OFFB_W-1:0] offB,
  input  logic [OFFJ_W-1:0] offJ,
  input  logic [OFFI_W-1:0] offI,
  input  ctrlStrobe_t       strobe,
  output cmpFlags_t         cmpFlags,
  output logic [XLEN-1:0]   nextPc,
  output logic              taken,
  output logic [XLEN-1:0]   linkVal,
  output logic              misaligned
);
  localparam int INSTR_BYTES = 4;
  localparam logic [XLEN-1:0] EVEN_MASK = ~{{(XLEN-1){1'b0}}, 1'b1};

  logic [XLEN-1:0] pcPlus4;
  logic [XLEN-1:0] extB;
  logic [XLEN-1:0] extJ;
  logic [XLEN-1:0] extI;
  logic [XLEN-1:0] tgtBr;
  logic [XLEN-1:0] tgtJmp;
  logic [XLEN-1:0] tgtReg;

  always_comb begin
    cmpFlags.eq  = (rs1Val == rs2Val);
    cmpFlags.ltS = ($signed(rs1Val) < $signed(rs2Val));
    cmpFlags.ltU = (rs1Val < rs2Val);
  end

  always_comb begin
    extB = {{(XLEN-OFFB_W){offB[OFFB_W-1]}}, offB} & EVEN_MASK;
    extJ = {{(XLEN-OFFJ_W){offJ[OFFJ_W-1]}}, offJ} & EVEN_MASK;
    extI = {{(XLEN-OFFI_W){offI[OFFI_W-1]}}, offI};
  end

  always_comb begin
    pcPlus4 = pcCur + XLEN'(INSTR_BYTES);
    tgtBr   = pcCur + extB;
    tgtJmp  = pcCur + extJ;
    tgtReg  = (rs1Val + extI) & EVEN_MASK;
  end

  always_comb begin
    unique case (strobe.tgtSel)
      TGT_BR:  nextPc = tgtBr;
      TGT_JMP: nextPc = tgtJmp;
      TGT_REG: nextPc = tgtReg;
      default: nextPc = pcPlus4;
    endcase
    taken      = (strobe.tgtSel != TGT_SEQ);
    linkVal    = pcPlus4;
    misaligned = taken && nextPc[1];
  end

  always_comb begin
    if (!taken) begin
      AST_SEQ_ADVANCE: assert (nextPc == pcCur + XLEN'(INSTR_BYTES)); // R6
    end
    if (taken) begin
      AST_TAKEN_EVEN: assert (nextPc[0] == 1'b0); // R8
    end
    if (misaligned) begin
      AST_MISALIGN_TAKEN: assert (taken && nextPc[1]); // R10
    end
  end
endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
  import nextpc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]   pcCur,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [F3_W-1:0]   funct3,
  input  logic [RIDX_W-1:0] rdIdx,
  input  logic [XLEN-1:0]   rs1Val,
  input  logic [XLEN-1:0]   rs2Val,
  input  logic [OFFB_W-1:0] offB,
  input  logic [OFFJ_W-1:0] offJ,
  input  logic [OFFI_W-1:0] offI,
  output logic [XLEN-1:0]   nextPc,
  output logic              taken,
  output logic [XLEN-1:0]   linkVal,
  output logic              linkWe,
  output logic              misaligned
);
  ctrlStrobe_t strobe;
  cmpFlags_t   cmpFlags;

  nextpc_ctrl u_ctrl (
    .opcode   (opcode),
    .funct3   (funct3),
    .rdIdx    (rdIdx),
    .cmpFlags (cmpFlags),
    .strobe   (strobe)
  );

  nextpc_dp #(.XLEN(XLEN)) u_dp (
    .pcCur      (pcCur),
    .rs1Val     (rs1Val),
    .rs2Val     (rs2Val),
    .offB       (offB),
    .offJ       (offJ),
    .offI       (offI),
    .strobe     (strobe),
    .cmpFlags   (cmpFlags),
    .nextPc     (nextPc),
    .taken      (taken),
    .linkVal    (linkVal),
    .misaligned (misaligned)
  );

  assign linkWe = strobe.linkWr;

  always_comb begin
    if (linkWe) begin
      AST_LINK_IMPLIES_TAKEN: assert (taken); // R9
    end
  end
endmodule

// File: tb/sim_nextpc_unit.sv
module sim_nextpc_unit;
  localparam int XLEN = 32;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG_CYCLES = 5000;

  typedef struct {
    logic [XLEN-1:0] nextPc;
    logic            taken;
    logic [XLEN-1:0] linkVal;
    logic            linkWe;
    logic            misaligned;
    string           req;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [XLEN-1:0] pcCur = '0;
  logic [6:0]  opcode = '0;
  logic [2:0]  funct3 = '0;
  logic [4:0]  rdIdx = '0;
  logic [XLEN-1:0] rs1Val = '0;
  logic [XLEN-1:0] rs2Val = '0;
  logic [12:0] offB = '0;
  logic [20:0] offJ = '0;
  logic [11:0] offI = '0;
  logic [XLEN-1:0] nextPc;
  logic            taken;
  logic [XLEN-1:0] linkVal;
  logic            linkWe;
  logic            misaligned;

  int checks = 0;
  int errors = 0;
  bit driverDone = 1'b0;
  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  nextpc_unit #(.XLEN(XLEN)) u0 (
    .pcCur(pcCur), .opcode(opcode), .funct3(funct3), .rdIdx(rdIdx),
    .rs1Val(rs1Val), .rs2Val(rs2Val), .offB(offB), .offJ(offJ), .offI(offI),
    .nextPc(nextPc), .taken(taken), .linkVal(linkVal), .linkWe(linkWe),
    .misaligned(misaligned)
  );

  function automatic expItem_t refModel(
    logic [XLEN-1:0] pc, logic [6:0] op, logic [2:0] f3, logic [4:0] rd,
    logic [XLEN-1:0] a, logic [XLEN-1:0] b, logic [12:0] ob,
    logic [20:0] oj, logic [11:0] oi, string req);
    expItem_t e;
    logic cond;
    int signed dispB;
    int signed dispJ;
    int signed dispI;
    dispB = int'($signed({ob[12:1], 1'b0}));
    dispJ = int'($signed({oj[20:1], 1'b0}));
    dispI = int'($signed(oi));
    e.req = req;
    e.linkVal = pc + 32'd4;
    e.linkWe = 1'b0;
    e.taken = 1'b0;
    e.nextPc = pc + 32'd4;
    case (f3)
      3'd0: cond = (a == b);
      3'd1: cond = (a != b);
      3'd4: cond = (int'($signed(a)) < int'($signed(b)));
      3'd5: cond = !(int'($signed(a)) < int'($signed(b)));
      3'd6: cond = (a < b);
      3'd7: cond = (a >= b);
      default: cond = 1'b0;
    endcase
    if (op == 7'h63 && cond) begin
      e.taken = 1'b1;
      e.nextPc = pc + 32'(dispB);
    end else if (op == 7'h6F) begin
      e.taken = 1'b1;
      e.nextPc = pc + 32'(dispJ);
      e.linkWe = (rd != 0);
    end else if (op == 7'h67 && f3 == 3'd0) begin
      e.taken = 1'b1;
      e.nextPc = (a + 32'(dispI));
      e.nextPc[0] = 1'b0;
      e.linkWe = (rd != 0);
    end
    e.misaligned = e.taken && e.nextPc[1];
    return e;
  endfunction

  task automatic drive(
    logic [XLEN-1:0] pc, logic [6:0] op, logic [2:0] f3, logic [4:0] rd,
    logic [XLEN-1:0] a, logic [XLEN-1:0] b, logic [12:0] ob,
    logic [20:0] oj, logic [11:0] oi, string req);
    @(posedge clk);
    #1;
    pcCur = pc; opcode = op; funct3 = f3; rdIdx = rd;
    rs1Val = a; rs2Val = b; offB = ob; offJ = oj; offI = oi;
    expQ.push_back(refModel(pc, op, f3, rd, a, b, ob, oj, oi, req));
  endtask

  task automatic cmpField(string req, string name, logic [XLEN-1:0] act,
                          logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, name, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      cmpField(e.req, "nextPc", nextPc, e.nextPc);
      cmpField(e.req, "taken", XLEN'(taken), XLEN'(e.taken));
      cmpField(e.req, "linkVal", linkVal, e.linkVal);
      cmpField(e.req, "linkWe", XLEN'(linkWe), XLEN'(e.linkWe));
      cmpField(e.req, "misaligned", XLEN'(misaligned), XLEN'(e.misaligned));
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    rstN = 1'b1;
    // reset state: all-zero inputs are a sequential instruction (R1)
    drive(32'h0, 7'h00, 3'd0, 5'd0, 32'h0, 32'h0, 13'h0, 21'h0, 12'h0, "R1");
    drive(32'h1000, 7'h33, 3'd0, 5'd3, 32'h5, 32'h5, 13'h40, 21'h80, 12'h10, "R1");
    drive(32'h1000, 7'h67, 3'd1, 5'd3, 32'h200, 32'h0, 13'h0, 21'h0, 12'h10, "R1");
    // equality branches (R2)
    drive(32'h2000, 7'h63, 3'd0, 5'd1, 32'h7, 32'h7, 13'h010, 21'h0, 12'h0, "R2");
    drive(32'h2000, 7'h63, 3'd0, 5'd1, 32'h7, 32'h8, 13'h010, 21'h0, 12'h0, "R2");
    drive(32'h2000, 7'h63, 3'd1, 5'd1, 32'h7, 32'h8, 13'h1FF0, 21'h0, 12'h0, "R2");
    drive(32'h2000, 7'h63, 3'd1, 5'd1, 32'h9, 32'h9, 13'h1FF0, 21'h0, 12'h0, "R2");
    // signed compares at the sign boundary (R3)
    drive(32'h3000, 7'h63, 3'd4, 5'd0, 32'h8000_0000, 32'h1, 13'h020, 21'h0, 12'h0, "R3");
    drive(32'h3000, 7'h63, 3'd4, 5'd0, 32'h1, 32'h8000_0000, 13'h020, 21'h0, 12'h0, "R3");
    drive(32'h3000, 7'h63, 3'd5, 5'd0, 32'h5, 32'h5, 13'h020, 21'h0, 12'h0, "R3");
    drive(32'h3000, 7'h63, 3'd5, 5'd0, 32'hFFFF_FFFF, 32'h0, 13'h020, 21'h0, 12'h0, "R3");
    // unsigned compares (R4)
    drive(32'h4000, 7'h63, 3'd6, 5'd0, 32'h1, 32'h8000_0000, 13'h008, 21'h0, 12'h0, "R4");
    drive(32'h4000, 7'h63, 3'd6, 5'd0, 32'hFFFF_FFFF, 32'h0, 13'h008, 21'h0, 12'h0, "R4");
    drive(32'h4000, 7'h63, 3'd7, 5'd0, 32'hFFFF_FFFF, 32'h0, 13'h008, 21'h0, 12'h0, "R4");
    drive(32'h4000, 7'h63, 3'd7, 5'd0, 32'h3, 32'h4, 13'h008, 21'h0, 12'h0, "R4");
    // reserved conditions (R5)
    drive(32'h5000, 7'h63, 3'd2, 5'd0, 32'h1, 32'h1, 13'h040, 21'h0, 12'h0, "R5");
    drive(32'h5000, 7'h63, 3'd3, 5'd0, 32'h1, 32'h9, 13'h040, 21'h0, 12'h0, "R5");
    // branch target with odd offset bit ignored and a misaligned target (R6, R10)
    drive(32'h6000, 7'h63, 3'd0, 5'd0, 32'h0, 32'h0, 13'h011, 21'h0, 12'h0, "R6");
    drive(32'h6000, 7'h63, 3'd0, 5'd0, 32'h0, 32'h0, 13'h006, 21'h0, 12'h0, "R10");
    // PC-relative jump (R7), link and rd zero (R9)
    drive(32'h7000, 7'h6F, 3'd5, 5'd1, 32'h0, 32'h0, 13'h0, 21'h1F_F001, 12'h0, "R7");
    drive(32'h7000, 7'h6F, 3'd0, 5'd0, 32'h0, 32'h0, 13'h0, 21'h0_0100, 12'h0, "R9");
    drive(32'h7000, 7'h6F, 3'd0, 5'd4, 32'h0, 32'h0, 13'h0, 21'h0_0002, 12'h0, "R10");
    // register jump clears bit 0 (R8)
    drive(32'h8000, 7'h67, 3'd0, 5'd5, 32'h1235, 32'h0, 13'h0, 21'h0, 12'h000, "R8");
    drive(32'h8000, 7'h67, 3'd0, 5'd5, 32'h1000, 32'h0, 13'h0, 21'h0, 12'hFFF, "R8");
    drive(32'h8000, 7'h67, 3'd0, 5'd0, 32'h2000, 32'h0, 13'h0, 21'h0, 12'h006, "R9");
    // wraparound (R11)
    drive(32'hFFFF_FFFC, 7'h13, 3'd0, 5'd1, 32'h0, 32'h0, 13'h0, 21'h0, 12'h0, "R11");
    drive(32'hFFFF_FFF0, 7'h6F, 3'd0, 5'd1, 32'h0, 32'h0, 13'h0, 21'h0_0020, 12'h0, "R11");
    drive(32'h0000_0008, 7'h63, 3'd0, 5'd0, 32'h0, 32'h0, 13'h1FF0, 21'h0, 12'h0, "R11");
    drive(32'h0, 7'h67, 3'd0, 5'd2, 32'hFFFF_FFFF, 32'h0, 13'h0, 21'h0, 12'h004, "R11");
    @(posedge clk);
    @(negedge clk);
    #1;
    driverDone = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!driverDone && cyc < WATCHDOG_CYCLES) begin
      @(posedge clk);
      cyc++;
    end
    if (!driverDone) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule